// File: doc/BRIEF.md
# Two-Wire Bus Serial Clock Generator

This block derives the serial clock of a two-wire (I2C-style) bus master from the system clock. One configuration word carries a divider for the low phase, a divider for the high phase and a power-of-two exponent that both phases share. Each phase lasts its divider shifted left by the exponent, plus a fixed offset of system cycles. The offset is a build-time parameter.

The bus engine reads two signals from the block: the current clock level and a one-cycle strobe that marks each level change. It drives a hold input to stop the clock in its low state, either between bytes or while a target stretches the clock. A new configuration word is picked up only at a phase boundary, so no phase is ever cut short. All pins are plain control and status signals. No data passes through the block, so there is no stream handshake.

Top module: `twi_sclk_gen`

## Requirements
- R1: While reset is active and right after it, `scl_o` is 1 and `phase_tgl_o` is 0.
- R2: The configuration word holds the low-phase divider in bits 7:0, the high-phase divider in bits 15:8 and the exponent in bits 18:16. A low phase lasts low_div × 2^exp + OFFSET system cycles. A high phase lasts high_div × 2^exp + OFFSET system cycles.
- R3: With equal dividers, one bus clock period is 2 × (div × 2^exp + OFFSET) cycles. With a 50 MHz system clock and OFFSET = 3, div = 247 and exp = 0 give a 100 kHz bus clock, which is a 500-cycle period.
- R4: An exponent field above the parameter EXP_MAX is handled as EXP_MAX.
- R5: A divider of 0 gives a phase of exactly OFFSET cycles.
- R6: A configuration word written during a phase does not change that phase. It sets the length of the phases that start at later boundaries.
- R7: While `hold` is 1 in a low phase, `scl_o` stays 0 and the phase count does not advance. When `hold` returns to 0, the phase resumes from its frozen count, so the low phase is longer by the number of held cycles.
- R8: A `hold` asserted during a high phase does not lengthen that phase. The high phase ends on time, and the following low phase is then held.
- R9: `phase_tgl_o` is 1 for exactly the one cycle in which `scl_o` takes a new level. `scl_o` does not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 19 | Low divider [7:0], high divider [15:8], exponent [18:16] |
| hold | input | 1 | Stops the clock once it is low |
| scl_o | output | 1 | Current serial clock level |
| phase_tgl_o | output | 1 | One-cycle strobe on each level change |

## Verification
The bench builds the block with OFFSET = 3 and EXP_MAX = 5. With EXP_MAX at 5, the 3-bit exponent field can carry 6 and 7, so the saturation path of R4 can be exercised. OFFSET = 3 combined with the 50 MHz bench clock puts the 100 kHz point at divider 247, which the bench checks to the exact cycle. The largest phase under this build is 255 × 32 + 3 cycles, which keeps every scenario short.

// File: rtl/twi_sclk_pkg.sv
package twi_sclk_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } sclk_level_e;
endpackage

// File: rtl/twi_sclk_len.sv
// Turns the configuration word into the cycle count of each phase.
module twi_sclk_len #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 7,
  parameter int OFFSET  = 4,
  parameter int LEN_W   = 16
) (
  input  logic [2*DIV_W+EXP_W-1:0] cfg,
  output logic [LEN_W-1:0]         len_low,
  output logic [LEN_W-1:0]         len_high
);
  localparam int PAD_W = LEN_W - DIV_W;

  logic [EXP_W-1:0] exp_field;
  logic [EXP_W-1:0] exp_eff;
  logic [LEN_W-1:0] len_arr [2];

  assign exp_field = cfg[2*DIV_W +: EXP_W];

  // Saturate the exponent at the largest legal value
  always_comb begin
    if (int'(exp_field) > EXP_MAX) exp_eff = EXP_W'(EXP_MAX);
    else                           exp_eff = exp_field;
  end

  // Index 0 is the low phase, index 1 is the high phase
  for (genvar p = 0; p < 2; p++) begin : g_phase
    logic [DIV_W-1:0] div;
    assign div        = cfg[p*DIV_W +: DIV_W];
    assign len_arr[p] = ({{PAD_W{1'b0}}, div} << exp_eff) + LEN_W'(OFFSET);
  end

  assign len_low  = len_arr[0];
  assign len_high = len_arr[1];
endmodule

// File: rtl/twi_sclk_ctr.sv
// Phase counter and level register.
module twi_sclk_ctr
  import twi_sclk_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [LEN_W-1:0] len_low,
  input  logic [LEN_W-1:0] len_high,
  output logic             level,
  output logic             tgl
);
  sclk_level_e      lvl_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             arm_q;
  logic             tgl_q;
  logic             last;

  assign last = (cnt_q + 1'b1) == len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LVL_HIGH;
      cnt_q <= '0;
      len_q <= '0;
      arm_q <= 1'b1;
      tgl_q <= 1'b0;
    end else begin
      tgl_q <= 1'b0;
      if (arm_q) begin
        // First cycle after reset: load the high-phase length
        len_q <= len_high;
        cnt_q <= '0;
        arm_q <= 1'b0;
      end else if (hold && lvl_q == LVL_LOW) begin
        // Clock held low: count and level frozen
        cnt_q <= cnt_q;
      end else if (last) begin
        // Phase boundary: switch level and load the next length
        cnt_q <= '0;
        tgl_q <= 1'b1;
        if (lvl_q == LVL_HIGH) begin
          lvl_q <= LVL_LOW;
          len_q <= len_low;
        end else begin
          lvl_q <= LVL_HIGH;
          len_q <= len_high;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level = (lvl_q == LVL_HIGH);
  assign tgl   = tgl_q;

  // R2: the count stays inside the loaded phase length
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q |-> (cnt_q < len_q));

  // R7: a held low phase keeps its count and stays low
  a_r7_frozen_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && lvl_q == LVL_LOW && !arm_q) |=> ($stable(cnt_q) && lvl_q == LVL_LOW));

  // R8: hold does not stretch a high phase before its last cycle
  a_r8_high_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && lvl_q == LVL_HIGH && !arm_q && !last) |=> (lvl_q == LVL_HIGH));

  // R9: the strobe comes only with a level change
  a_r9_strobe_has_change: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_q |-> (lvl_q != $past(lvl_q)));

  // R9: every level change comes with the strobe
  a_r9_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> tgl_q);
endmodule

// File: rtl/twi_sclk_gen.sv
module twi_sclk_gen #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 7,
  parameter int OFFSET  = 4,
  localparam int CFG_W  = 2*DIV_W + EXP_W,
  localparam int LEN_W  = DIV_W + EXP_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             hold,
  output logic             scl_o,
  output logic             phase_tgl_o
);
  logic [LEN_W-1:0] len_low;
  logic [LEN_W-1:0] len_high;

  twi_sclk_len #(
    .DIV_W  (DIV_W),
    .EXP_W  (EXP_W),
    .EXP_MAX(EXP_MAX),
    .OFFSET (OFFSET),
    .LEN_W  (LEN_W)
  ) u_len (
    .cfg     (cfg_word),
    .len_low (len_low),
    .len_high(len_high)
  );

  twi_sclk_ctr #(
    .LEN_W(LEN_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .len_low (len_low),
    .len_high(len_high),
    .level   (scl_o),
    .tgl     (phase_tgl_o)
  );

  // R1: right after reset the clock idles high with no strobe
  a_r1_idle_high: assert property (@(posedge clk)
    !rst_n |=> (scl_o && !phase_tgl_o));
endmodule

// File: tb/test_twi_sclk_gen.sv
module test_twi_sclk_gen;
  localparam int OFS  = 3;
  localparam int EMAX = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] cfg_word = '0;
  logic        hold = 1'b0;
  logic        scl_o;
  logic        phase_tgl_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  twi_sclk_gen #(.EXP_MAX(EMAX), .OFFSET(OFS)) i_twi_sclk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .hold(hold),
    .scl_o(scl_o), .phase_tgl_o(phase_tgl_o)
  );

  function automatic logic [18:0] mk(int lo, int hi, int ex);
    return {ex[2:0], hi[7:0], lo[7:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge();
    do @(negedge clk); while (!phase_tgl_o);
  endtask

  // Positioned on a strobe sample; counts until the next strobe sample
  task automatic meas(output int n, output logic lvl);
    int bad;
    lvl = scl_o;
    n = 0;
    bad = 0;
    do begin
      @(negedge clk);
      n++;
      if (!phase_tgl_o && scl_o != lvl) bad++;
    end while (!phase_tgl_o);
    chk("R9 level steady within phase", bad, 0);
  endtask

  task automatic meas_pair(output int nlo, output int nhi);
    int a, b;
    logic la, lb;
    meas(a, la);
    meas(b, lb);
    chk("R9 levels alternate", int'(la ^ lb), 1);
    if (la) begin nhi = a; nlo = b; end
    else    begin nlo = a; nhi = b; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_word = mk(10, 10, 0);
    repeat (3) @(negedge clk);
    chk("R1 scl high in reset", int'(scl_o), 1);
    chk("R1 no strobe in reset", int'(phase_tgl_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl high after reset", int'(scl_o), 1);
    chk("R1 no strobe after reset", int'(phase_tgl_o), 0);
  endtask

  task automatic t_equal_100k();
    int lo, hi;
    cfg_word = mk(247, 247, 0);
    wait_edge(); wait_edge();
    meas_pair(lo, hi);
    chk("R2 low 247", lo, 250);
    chk("R2 high 247", hi, 250);
    chk("R3 period 100kHz", lo + hi, 500);
  endtask

  task automatic t_split();
    int lo, hi;
    cfg_word = mk(5, 20, 2);
    wait_edge(); wait_edge();
    meas_pair(lo, hi);
    chk("R2 split low", lo, 5*4 + OFS);
    chk("R2 split high", hi, 20*4 + OFS);
  endtask

  task automatic t_clamp();
    int lo, hi;
    cfg_word = mk(2, 3, 7);
    wait_edge(); wait_edge();
    meas_pair(lo, hi);
    chk("R4 exp 7 clamped low", lo, 2*32 + OFS);
    chk("R4 exp 7 clamped high", hi, 3*32 + OFS);
    cfg_word = mk(1, 1, 6);
    wait_edge(); wait_edge();
    meas_pair(lo, hi);
    chk("R4 exp 6 clamped", lo, 32 + OFS);
  endtask

  task automatic t_zero();
    int lo, hi;
    cfg_word = mk(0, 1, 1);
    wait_edge(); wait_edge();
    meas_pair(lo, hi);
    chk("R5 zero divider", lo, OFS);
    chk("R5 neighbour", hi, 2 + OFS);
  endtask

  task automatic t_change();
    int a, b;
    logic la, lb;
    cfg_word = mk(10, 10, 0);
    wait_edge(); wait_edge();
    cfg_word = mk(30, 30, 0);
    meas(a, la);
    meas(b, lb);
    chk("R6 current phase keeps old", a, 10 + OFS);
    chk("R6 next phase takes new", b, 30 + OFS);
  endtask

  task automatic t_hold_low();
    int n, hi_seen, lo_len;
    logic lvl;
    cfg_word = mk(12, 12, 0);
    wait_edge(); wait_edge();
    if (scl_o) wait_edge();
    hold = 1'b1;
    hi_seen = 0;
    n = 0;
    repeat (40) begin
      @(negedge clk);
      n++;
      if (scl_o || phase_tgl_o) hi_seen++;
    end
    hold = 1'b0;
    chk("R7 scl low while held", hi_seen, 0);
    meas(lo_len, lvl);
    chk("R7 low phase stretched", n + lo_len, 12 + OFS + 40);
  endtask

  task automatic t_hold_high();
    int hi_len, n, bad, rest;
    logic lvl;
    cfg_word = mk(8, 16, 0);
    wait_edge(); wait_edge();
    if (!scl_o) wait_edge();
    hold = 1'b1;
    meas(hi_len, lvl);
    chk("R8 high phase not stretched", hi_len, 16 + OFS);
    bad = 0;
    n = 0;
    repeat (30) begin
      @(negedge clk);
      n++;
      if (scl_o || phase_tgl_o) bad++;
    end
    hold = 1'b0;
    chk("R8 following low held", bad, 0);
    meas(rest, lvl);
    chk("R8 low phase after hold", n + rest, 8 + OFS + 30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_equal_100k();
    t_split();
    t_clamp();
    t_zero();
    t_change();
    t_hold_low();
    t_hold_high();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule